// File: doc/BRIEF.md
# Load/Store Sub-Word Data Aligner

This block sits between the execute stage of a 32-bit core and a word-organised data memory that answers reads one clock after the request. In the request cycle it adds the sign-extended 16-bit displacement to the base register value to form the byte address. It decodes the memory opcode and then either issues a read, or drives byte-lane write enables together with the store value copied into the lanes it will land in.

In the following cycle it takes the word returned by memory and picks out the addressed byte or halfword. It then widens that value to 32 bits by sign or zero extension, as the opcode asks, and presents it as the register write-back value. An access whose address does not suit its width raises a flag, and then neither a read nor a write reaches memory.

Top module: `lsa_aligner`

## Requirements
- R1: While `req_valid` is high, `mem_addr` equals `base_val` plus `disp` sign-extended from 16 to 32 bits, modulo 2^32.
- R2: Only the opcodes 0x20, 0x21, 0x23, 0x24 and 0x25 (loads) and 0x28, 0x29 and 0x2b (stores) touch memory. Any other opcode, or `req_valid` low, gives `mem_rd_en` 0, `mem_wstrb` 0, `misaligned` 0 and no load result in the next cycle.
- R3: An aligned store sets write enables by little-endian lane, where lane k holds data bits 8k+7:8k. For a byte store (0x28) the enable is 1 shifted left by address bits 1:0. For a halfword store (0x29) it is 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1. For a word store (0x2b) it is 4'b1111.
- R4: Store data is steered into the lanes. A byte store drives source bits 7:0 into every lane, and a halfword store drives source bits 15:0 into both halves, so upper source bits never reach memory. A word store passes the source unchanged.
- R5: A halfword access with address bit 0 set, or a word access with address bits 1:0 nonzero, raises `misaligned` and forces `mem_wstrb` to 0 and `mem_rd_en` to 0. Byte accesses never raise it.
- R6: `load_valid` is high in the cycle after an aligned load request and low in every other cycle.
- R7: Signed loads (0x20 byte, 0x21 halfword) return the lane selected by the request address, sign-extended to 32 bits.
- R8: Unsigned loads (0x24 byte, 0x25 halfword) return the selected lane zero-extended to 32 bits.
- R9: A word load (0x23) returns `mem_rdata` unchanged.
- R10: While `rst_n` is low at a clock edge, the pending-load state clears, so `load_valid` is 0 in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A memory instruction is presented this cycle |
| opcode | input | 6 | Primary opcode of the instruction |
| base_val | input | 32 | Base register value |
| disp | input | 16 | Signed displacement |
| store_src | input | 32 | Store source register value |
| mem_addr | output | 32 | Effective byte address |
| mem_rd_en | output | 1 | Read request to memory |
| mem_wstrb | output | 4 | Byte-lane write enables |
| mem_wdata | output | 32 | Lane-positioned store data |
| misaligned | output | 1 | Address does not suit the access width |
| mem_rdata | input | 32 | Word returned by memory one cycle after the read |
| load_valid | output | 1 | `load_result` holds a finished load |
| load_result | output | 32 | Extended load value for write-back |

## Verification
The only state is the pending-load record of lane, width and signedness. If it is corrupted, the fault shows in the cycle right after the request: the wrong byte appears in `load_result`, the upper bits are extended wrongly, or `load_valid` is missing or spurious. A decode or lane-steering fault shows in the request cycle itself, as a wrong `mem_wstrb` pattern, wrong lane copies in `mem_wdata`, or a read or write that leaks out of a misaligned access. The stimulus therefore sweeps every opcode over all four low-address values with random data, and adds directed cases for negative displacements, address wrap, and sign bits set and clear.

// File: rtl/lsa_pkg.sv
// Shared types for the load/store aligner.
// Assumes a 32-bit data path split into four little-endian byte lanes.
package lsa_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_NONE = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic      is_load;
        logic      is_store;
        logic      is_signed;
        acc_size_e size;
    } acc_info_t;

    localparam logic [5:0] OPC_LD_BS = 6'h20;
    localparam logic [5:0] OPC_LD_HS = 6'h21;
    localparam logic [5:0] OPC_LD_W  = 6'h23;
    localparam logic [5:0] OPC_LD_BU = 6'h24;
    localparam logic [5:0] OPC_LD_HU = 6'h25;
    localparam logic [5:0] OPC_ST_B  = 6'h28;
    localparam logic [5:0] OPC_ST_H  = 6'h29;
    localparam logic [5:0] OPC_ST_W  = 6'h2b;

endpackage

// File: rtl/lsa_decode.sv
// Opcode decoder: classifies an opcode as load, store or neither, and
// gives its access width and signedness.
// Assumes opcodes outside the eight memory codes are not memory operations.
module lsa_decode
    import lsa_pkg::*;
#(
    parameter int OP_W = 6
) (
    input  logic [OP_W-1:0] opcode,
    output acc_info_t       info
);

    // Table decode of the memory opcodes.
    always_comb begin
        info = '{is_load: 1'b0, is_store: 1'b0, is_signed: 1'b0, size: SZ_NONE};
        unique case (opcode)
            OPC_LD_BS: info = '{is_load: 1'b1, is_store: 1'b0, is_signed: 1'b1, size: SZ_BYTE};
            OPC_LD_HS: info = '{is_load: 1'b1, is_store: 1'b0, is_signed: 1'b1, size: SZ_HALF};
            OPC_LD_W:  info = '{is_load: 1'b1, is_store: 1'b0, is_signed: 1'b0, size: SZ_WORD};
            OPC_LD_BU: info = '{is_load: 1'b1, is_store: 1'b0, is_signed: 1'b0, size: SZ_BYTE};
            OPC_LD_HU: info = '{is_load: 1'b1, is_store: 1'b0, is_signed: 1'b0, size: SZ_HALF};
            OPC_ST_B:  info = '{is_load: 1'b0, is_store: 1'b1, is_signed: 1'b0, size: SZ_BYTE};
            OPC_ST_H:  info = '{is_load: 1'b0, is_store: 1'b1, is_signed: 1'b0, size: SZ_HALF};
            OPC_ST_W:  info = '{is_load: 1'b0, is_store: 1'b1, is_signed: 1'b0, size: SZ_WORD};
            default:   ;
        endcase
    end

endmodule

// File: rtl/lsa_store_lane.sv
// Lane planner: from the low address bits and the access width, it works
// out which byte lanes the access covers, copies the store source into
// those lanes, and flags addresses that do not suit the width.
// Assumes four byte lanes, little-endian (lane k = bits 8k+7:8k).
module lsa_store_lane
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  acc_size_e                     size,
    input  logic [$clog2(DATA_W/8)-1:0]   addr_lo,
    input  logic [DATA_W-1:0]             src,
    output logic [DATA_W/8-1:0]           lane_sel,
    output logic [DATA_W-1:0]             lane_data,
    output logic                          bad_align
);

    localparam int NLANE = DATA_W / 8;

    // Alignment rule: halfwords need bit 0 clear, words need bits 1:0 clear.
    always_comb begin
        unique case (size)
            SZ_HALF: bad_align = addr_lo[0];
            SZ_WORD: bad_align = |addr_lo[1:0];
            default: bad_align = 1'b0;
        endcase
    end

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        // Per-lane enable and source byte for the given width.
        always_comb begin
            unique case (size)
                SZ_BYTE: begin
                    lane_sel[i]         = (addr_lo == i[$clog2(NLANE)-1:0]);
                    lane_data[8*i +: 8] = src[7:0];
                end
                SZ_HALF: begin
                    lane_sel[i]         = (addr_lo[1] == i[1]);
                    lane_data[8*i +: 8] = src[8*(i%2) +: 8];
                end
                SZ_WORD: begin
                    lane_sel[i]         = 1'b1;
                    lane_data[8*i +: 8] = src[8*i +: 8];
                end
                default: begin
                    lane_sel[i]         = 1'b0;
                    lane_data[8*i +: 8] = src[8*i +: 8];
                end
            endcase
        end
    end

endmodule

// File: rtl/lsa_load_extract.sv
// Load extractor: picks the addressed byte or halfword out of a returned
// memory word and widens it to the full width by sign or zero extension.
// Assumes four little-endian byte lanes and a naturally aligned address.
module lsa_load_extract
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]           rdata,
    input  logic [$clog2(DATA_W/8)-1:0] addr_lo,
    input  acc_size_e                   size,
    input  logic                        is_signed,
    output logic [DATA_W-1:0]           result
);

    localparam int NLANE = DATA_W / 8;

    logic [7:0]  lane_b [NLANE];
    logic [7:0]  pick_b;
    logic [15:0] pick_h;

    for (genvar i = 0; i < NLANE; i++) begin : g_split
        assign lane_b[i] = rdata[8*i +: 8];
    end

    // Lane selection for the byte and halfword cases.
    always_comb begin
        pick_b = lane_b[addr_lo];
        pick_h = addr_lo[1] ? rdata[31:16] : rdata[15:0];
    end

    // Width-dependent extension to the full register width.
    always_comb begin
        unique case (size)
            SZ_BYTE: result = {{(DATA_W-8){is_signed & pick_b[7]}}, pick_b};
            SZ_HALF: result = {{(DATA_W-16){is_signed & pick_h[15]}}, pick_h};
            default: result = rdata;
        endcase
    end

endmodule

// File: rtl/lsa_aligner.sv
// Load/store aligner top. Request cycle: forms the effective address,
// decodes the opcode, and issues either a read or lane-steered write,
// unless the access is misaligned. Next cycle: extends the returned word
// into the load result. Assumes memory returns read data exactly one
// cycle after mem_rd_en.
module lsa_aligner
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DISP_W = 16,
    parameter int OP_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [OP_W-1:0]   opcode,
    input  logic [DATA_W-1:0] base_val,
    input  logic [DISP_W-1:0] disp,
    input  logic [DATA_W-1:0] store_src,
    output logic [DATA_W-1:0] mem_addr,
    output logic              mem_rd_en,
    output logic [DATA_W/8-1:0] mem_wstrb,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              misaligned,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              load_valid,
    output logic [DATA_W-1:0] load_result
);

    localparam int NLANE = DATA_W / 8;
    localparam int LO_W  = $clog2(NLANE);

    acc_info_t               info;
    logic [NLANE-1:0]        lane_sel;
    logic                    bad_align;
    logic                    mem_op;
    logic                    pend_q;
    logic [LO_W-1:0]         pend_lo_q;
    acc_size_e               pend_size_q;
    logic                    pend_sgn_q;

    // Effective address: base plus sign-extended displacement.
    assign mem_addr = base_val + {{(DATA_W-DISP_W){disp[DISP_W-1]}}, disp};

    lsa_decode #(.OP_W(OP_W)) u_dec (
        .opcode (opcode),
        .info   (info)
    );

    lsa_store_lane #(.DATA_W(DATA_W)) u_lane (
        .size      (info.size),
        .addr_lo   (mem_addr[LO_W-1:0]),
        .src       (store_src),
        .lane_sel  (lane_sel),
        .lane_data (mem_wdata),
        .bad_align (bad_align)
    );

    // Request-cycle gating of read, write and the misaligned flag.
    always_comb begin
        mem_op     = req_valid & (info.is_load | info.is_store);
        misaligned = mem_op & bad_align;
        mem_rd_en  = req_valid & info.is_load & ~bad_align;
        mem_wstrb  = (req_valid & info.is_store & ~bad_align) ? lane_sel : '0;
    end

    // Holds the lane, width and signedness of an issued load until data returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_lo_q   <= '0;
            pend_size_q <= SZ_NONE;
            pend_sgn_q  <= 1'b0;
        end else begin
            pend_q      <= mem_rd_en;
            pend_lo_q   <= mem_addr[LO_W-1:0];
            pend_size_q <= info.size;
            pend_sgn_q  <= info.is_signed;
        end
    end

    lsa_load_extract #(.DATA_W(DATA_W)) u_ext (
        .rdata     (mem_rdata),
        .addr_lo   (pend_lo_q),
        .size      (pend_size_q),
        .is_signed (pend_sgn_q),
        .result    (load_result)
    );

    assign load_valid = pend_q;

    // Misaligned access must not reach memory (R5).
    p_mis_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        misaligned |-> (mem_wstrb == '0 && !mem_rd_en));

    // A byte store enables exactly one lane (R3).
    p_byte_one_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && opcode == OPC_ST_B) |-> ($countones(mem_wstrb) == 1));

    // An aligned halfword store enables one aligned lane pair (R3).
    p_half_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && opcode == OPC_ST_H && !misaligned)
            |-> (mem_wstrb == 4'b0011 || mem_wstrb == 4'b1100));

    // Reads and writes are never issued together (R2).
    p_rd_wr_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (mem_wstrb == '0));

    // An issued read is answered in the next cycle (R6).
    p_load_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> load_valid);

    // A load result only appears after a read was issued (R6).
    p_load_has_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid |-> $past(mem_rd_en));

    // Unsigned byte results carry zero upper bits (R8).
    p_ubyte_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && pend_size_q == SZ_BYTE && !pend_sgn_q)
            |-> (load_result[DATA_W-1:8] == '0));

    // Signed halfword results replicate bit 15 upward (R7).
    p_shalf_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && pend_size_q == SZ_HALF && pend_sgn_q)
            |-> (load_result[DATA_W-1:16] == {(DATA_W-16){load_result[15]}}));

endmodule

// File: tb/sim_lsa_aligner.sv
module sim_lsa_aligner;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [5:0]  opcode;
    logic [31:0] base_val;
    logic [15:0] disp;
    logic [31:0] store_src;
    logic [31:0] mem_addr;
    logic        mem_rd_en;
    logic [3:0]  mem_wstrb;
    logic [31:0] mem_wdata;
    logic        misaligned;
    logic [31:0] mem_rdata;
    logic        load_valid;
    logic [31:0] load_result;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    lsa_aligner u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .opcode(opcode),
        .base_val(base_val), .disp(disp), .store_src(store_src),
        .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_wstrb(mem_wstrb),
        .mem_wdata(mem_wdata), .misaligned(misaligned), .mem_rdata(mem_rdata),
        .load_valid(load_valid), .load_result(load_result)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Width in bytes of a memory opcode, 0 for anything else.
    function automatic int op_bytes(input logic [5:0] op);
        case (op)
            6'h20, 6'h24, 6'h28: return 1;
            6'h21, 6'h25, 6'h29: return 2;
            6'h23, 6'h2b:        return 4;
            default:             return 0;
        endcase
    endfunction

    function automatic bit op_load(input logic [5:0] op);
        return op inside {6'h20, 6'h21, 6'h23, 6'h24, 6'h25};
    endfunction

    function automatic bit op_store(input logic [5:0] op);
        return op inside {6'h28, 6'h29, 6'h2b};
    endfunction

    function automatic bit bad_addr(input int nb, input logic [1:0] lo);
        if (nb == 2) return lo[0];
        if (nb == 4) return lo != 2'b00;
        return 1'b0;
    endfunction

    function automatic logic [3:0] exp_strobe(input int nb, input logic [1:0] lo);
        if (nb == 1) return 4'b0001 << lo;
        if (nb == 2) return lo[1] ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    function automatic logic [31:0] exp_wdata(input int nb, input logic [31:0] s);
        if (nb == 1) return {4{s[7:0]}};
        if (nb == 2) return {2{s[15:0]}};
        return s;
    endfunction

    function automatic logic [31:0] exp_load(input logic [5:0] op, input logic [1:0] lo,
                                             input logic [31:0] w);
        logic [7:0]  b;
        logic [15:0] h;
        b = w >> (8 * lo);
        h = lo[1] ? w[31:16] : w[15:0];
        case (op)
            6'h20:   return {{24{b[7]}}, b};
            6'h24:   return {24'h0, b};
            6'h21:   return {{16{h[15]}}, h};
            6'h25:   return {16'h0, h};
            default: return w;
        endcase
    endfunction

    // One request cycle followed by one response cycle, both checked.
    task automatic do_op(input logic [5:0] op, input logic [31:0] b, input logic [15:0] d,
                         input logic [31:0] s, input logic [31:0] rword);
        logic [31:0] ea;
        int nb;
        bit mis, ld, st;
        ea  = b + {{16{d[15]}}, d};
        nb  = op_bytes(op);
        ld  = op_load(op);
        st  = op_store(op);
        mis = bad_addr(nb, ea[1:0]);
        @(negedge clk);
        req_valid = 1'b1; opcode = op; base_val = b; disp = d; store_src = s;
        #1;
        chk("R1 addr", mem_addr, ea);
        chk("R5 misaligned", {31'b0, misaligned}, {31'b0, (ld | st) & mis});
        chk("R2 rd_en", {31'b0, mem_rd_en}, {31'b0, ld & ~mis});
        if (st && !mis) begin
            chk("R3 strobe", {28'b0, mem_wstrb}, {28'b0, exp_strobe(nb, ea[1:0])});
            chk("R4 wdata", mem_wdata, exp_wdata(nb, s));
        end else begin
            chk("R2/R5 no strobe", {28'b0, mem_wstrb}, 32'h0);
        end
        @(negedge clk);
        req_valid = 1'b0; mem_rdata = rword;
        #1;
        chk("R6 load_valid", {31'b0, load_valid}, {31'b0, ld & ~mis});
        if (ld && !mis) begin
            if (nb == 4)
                chk("R9 word", load_result, exp_load(op, ea[1:0], rword));
            else if (op == 6'h20 || op == 6'h21)
                chk("R7 signed", load_result, exp_load(op, ea[1:0], rword));
            else
                chk("R8 unsigned", load_result, exp_load(op, ea[1:0], rword));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [5:0] ops [8];
        ops = '{6'h20, 6'h21, 6'h23, 6'h24, 6'h25, 6'h28, 6'h29, 6'h2b};
        void'($urandom(32'd20240611));
        rst_n = 1'b0; req_valid = 1'b1; opcode = 6'h23; base_val = '0; disp = '0;
        store_src = '0; mem_rdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; rst_n = 1'b1;
        #1;
        chk("R10 reset load_valid", {31'b0, load_valid}, 32'h0);
        chk("R2 idle strobe", {28'b0, mem_wstrb}, 32'h0);

        // Directed: every opcode at every low-address value.
        foreach (ops[k]) begin
            for (int lo = 0; lo < 4; lo++)
                do_op(ops[k], 32'h0000_1000 + lo, 16'h0000, 32'hA5C3_96F1, 32'h80FF_7F01);
        end
        // Directed: negative displacement, address wrap, sign boundaries.
        do_op(6'h20, 32'h0000_0010, 16'hFFFD, 32'h0, 32'h7F80_0000);
        do_op(6'h21, 32'h0000_0002, 16'hFFFC, 32'h0, 32'h8000_7FFF);
        do_op(6'h25, 32'hFFFF_FFFE, 16'h0004, 32'h0, 32'hFFFF_1234);
        do_op(6'h28, 32'h1234_5678, 16'h8001, 32'hDEAD_BE7E, 32'h0);
        do_op(6'h29, 32'h0000_0002, 16'h7FFE, 32'hFFFF_0080, 32'h0);
        do_op(6'h00, 32'h0000_0001, 16'h0000, 32'hFFFF_FFFF, 32'h1111_1111);
        do_op(6'h2a, 32'h0000_0000, 16'h0000, 32'hFFFF_FFFF, 32'h2222_2222);

        // Random mix, mostly memory opcodes.
        for (int n = 0; n < 600; n++) begin
            logic [5:0] op;
            if (($urandom % 8) == 0) op = 6'($urandom);
            else op = ops[$urandom % 8];
            do_op(op, $urandom, 16'($urandom), $urandom, $urandom);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule